// File: doc/BRIEF.md
# Tri-Level Service Watchdog

This block supervises a host by watching a service line that the host is expected to toggle. The line arrives already digitised as a two-bit level code: low, high, or mid/floating. Each change of level restarts a timeout counter. If the line sits at low or at high for a whole timeout period, the block pulls its active-low fault output low and raises a one-cycle strobe that a separate reset generator consumes. While the stall lasts, the counter restarts after each strobe, so a stuck host produces a strobe once per period. Parking the line at the mid level disables supervision altogether. A low-supply indication also keeps the fault output inactive.

The time base is selectable. With the internal base, a prescaler divides the system clock to a 1 kHz tick, and a speed input picks a short or a long timeout. With the external base, the block counts rising edges of an external tick input, which is synchronised first. The service code also passes through a two-flop synchroniser before it is decoded.

Top module: `svc_watchdog`

## Requirements
- R1: In reset and in the first cycle after it, `wdo_n` is 1 and `timeout_stb` is 0.
- R2: Service code 2'b10 and 2'b11 both mean mid/floating. While the synchronised code is mid, no strobe is issued, `wdo_n` is 1, and the count is held at zero.
- R3: Service code 2'b00 is low and 2'b01 is high. Every change of decoded level, including changes to or from mid, restarts the count from zero. A line that toggles faster than the timeout never times out.
- R4: If the decoded level stays low or stays high for a full timeout, `wdo_n` goes to 0 in the same cycle as a one-cycle `timeout_stb` pulse.
- R5: While the stall continues, the counter restarts after each strobe. Strobes then repeat exactly one timeout period apart, each one cycle wide, and `wdo_n` stays 0.
- R6: After a timeout, the first change of the service code to another level returns `wdo_n` to 1, three clock edges after the new code is applied.
- R7: While `low_line` is 1, `wdo_n` is 1 in the same cycle, no strobe is issued, and the count restarts.
- R8: With `base_sel`=1, one tick occurs every CLK_DIV clocks. With `speed_sel`=1 the timeout is FAST_TICKS ticks; with `speed_sel`=0 it is SLOW_TICKS ticks.
- R9: With `base_sel`=0, the timeout is EXT_TICKS rising edges of the synchronised `ext_tick`. Without edges on `ext_tick`, no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_code | input | 2 | Service line level code: 00 low, 01 high, 1x mid |
| base_sel | input | 1 | 1 selects the internal prescaled base, 0 selects external ticks |
| speed_sel | input | 1 | With the internal base: 1 fast timeout, 0 slow timeout |
| ext_tick | input | 1 | External time-base clock (asynchronous) |
| low_line | input | 1 | Low-supply indication, active high, synchronous |
| wdo_n | output | 1 | Watchdog fault output, active low |
| timeout_stb | output | 1 | One-cycle pulse for each timeout event |

## Verification
The line is driven with several patterns. Fast low/high toggling shows that each transition restarts the count. A long hold at low, and another at high, shows the first timeout and the repeated strobes, and the spacing between strobes is measured for both speeds. A stall interrupted by `low_line` shows that the forced inactive state differs from a plain restart, and parking at both mid codes shows that the timer is disabled. Under the external base, the bench runs the line once with no tick edges and once with a steady tick train, which tells counting of ticks apart from counting of system clocks.

// File: rtl/svc_wdog_pkg.sv
// Package: shared level encoding for the service-line watchdog.
// Assumes the service code is already digitised into two bits.
package svc_wdog_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } lvl_e;

    // Code that the synchroniser presents during reset (mid: timer idle).
    localparam logic [1:0] CODE_IDLE = 2'b10;

    // Map the raw two-bit code to a level; both codes with bit 1 set are mid.
    function automatic lvl_e decode_lvl(input logic [1:0] code);
        if (code[1])
            return LVL_MID;
        else if (code[0])
            return LVL_HIGH;
        else
            return LVL_LOW;
    endfunction

endpackage

// File: rtl/svc_wdog_sync.sv
// Module: two-flop synchroniser for a bus of independent asynchronous bits.
// Assumes each bit may be resampled independently (no multi-bit coherence needed
// beyond what the two-stage settling gives); RST_VAL sets the reset content.
module svc_wdog_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two-stage resampling into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign q_sync = stage2_q;

endmodule

// File: rtl/svc_wdog_base.sv
// Module: time-base unit. It produces a one-cycle advance pulse, either from a
// free-running prescaler (internal base) or from rising edges of the
// synchronised external tick. Assumes CLK_DIV >= 2.
module svc_wdog_base #(
    parameter int CLK_DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_sel,
    input  logic ext_tick_s,
    output logic advance
);

    localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_DIV - 1);

    logic [PW-1:0] pre_q;
    logic          pre_tick;
    logic          ext_prev_q;
    logic          ext_rise;

    assign pre_tick = (pre_q == PRE_LAST);
    assign ext_rise = ext_tick_s & ~ext_prev_q;

    // Free-running prescaler that wraps every CLK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (pre_tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    // Previous external tick level, used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ext_prev_q <= 1'b0;
        else
            ext_prev_q <= ext_tick_s;
    end

    // Pick the advance source.
    always_comb begin
        advance = base_sel ? pre_tick : ext_rise;
    end

    // Advance pulses never come on two cycles in a row.
    p_adv_sparse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> !advance);

endmodule

// File: rtl/svc_wdog_timer.sv
// Module: timeout counter. It counts advance pulses, clears on restart, and
// fires once when the selected limit is reached, then starts over from zero.
// Assumes the limits are at least 1; a limit that drops below the current
// count (speed change) fires on the next advance.
module svc_wdog_timer #(
    parameter int FAST_TICKS = 100,
    parameter int SLOW_TICKS = 1600,
    parameter int EXT_TICKS  = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_sel,
    input  logic speed_sel,
    input  logic restart,
    input  logic advance,
    output logic fire
);

    localparam int MAX_A   = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
    localparam int MAX_LIM = (MAX_A > EXT_TICKS) ? MAX_A : EXT_TICKS;
    localparam int CW      = $clog2(MAX_LIM + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;
    logic          at_end;

    // Limit chosen by the time base and the speed input.
    always_comb begin
        if (!base_sel)
            limit = CW'(EXT_TICKS);
        else if (speed_sel)
            limit = CW'(FAST_TICKS);
        else
            limit = CW'(SLOW_TICKS);
    end

    assign at_end = (cnt_q >= limit - 1'b1);
    assign fire   = !restart && advance && at_end;

    // Count advances; wrap to zero on a timeout or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || fire)
            cnt_q <= '0;
        else if (advance)
            cnt_q <= cnt_q + 1'b1;
    end

    // The count never reaches the largest limit.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(MAX_LIM));

    // After a timeout the count starts over from zero (R5).
    p_restart_after_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cnt_q == '0));

endmodule

// File: rtl/svc_watchdog.sv
// Module: tri-level service watchdog top. It synchronises the service code and
// the external tick, decodes the level, restarts the timer on every level
// change, and holds the fault flag and the strobe register.
// Assumes base_sel, speed_sel and low_line are already synchronous to clk.
module svc_watchdog #(
    parameter int CLK_DIV    = 100000,
    parameter int FAST_TICKS = 100,
    parameter int SLOW_TICKS = 1600,
    parameter int EXT_TICKS  = 1600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] svc_code,
    input  logic       base_sel,
    input  logic       speed_sel,
    input  logic       ext_tick,
    input  logic       low_line,
    output logic       wdo_n,
    output logic       timeout_stb
);

    import svc_wdog_pkg::*;

    logic [2:0] sync_q;
    logic [1:0] code_s;
    logic       ext_s;
    lvl_e       lvl_now;
    lvl_e       lvl_q;
    logic       svc_edge;
    logic       svc_mid;
    logic       restart;
    logic       advance;
    logic       fire;
    logic       fault_q;
    logic       stb_q;

    svc_wdog_sync #(
        .W       (3),
        .RST_VAL ({1'b0, CODE_IDLE})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_tick, svc_code}),
        .q_sync  (sync_q)
    );

    assign code_s = sync_q[1:0];
    assign ext_s  = sync_q[2];

    assign lvl_now  = decode_lvl(code_s);
    assign svc_edge = (lvl_now != lvl_q);
    assign svc_mid  = (lvl_now == LVL_MID);
    assign restart  = svc_edge | svc_mid | low_line;

    // Remember the previous decoded level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= LVL_MID;
        else
            lvl_q <= lvl_now;
    end

    svc_wdog_base #(
        .CLK_DIV (CLK_DIV)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_sel   (base_sel),
        .ext_tick_s (ext_s),
        .advance    (advance)
    );

    svc_wdog_timer #(
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS),
        .EXT_TICKS  (EXT_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_sel  (base_sel),
        .speed_sel (speed_sel),
        .restart   (restart),
        .advance   (advance),
        .fire      (fire)
    );

    // Fault flag: set by a timeout, cleared by a level change, mid, or low line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (restart)
            fault_q <= 1'b0;
        else if (fire)
            fault_q <= 1'b1;
    end

    // Register the timeout event as a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stb_q <= 1'b0;
        else
            stb_q <= fire;
    end

    assign wdo_n       = ~(fault_q & ~low_line);
    assign timeout_stb = stb_q;

    // The fault output only falls together with a strobe.
    p_fault_with_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) && !$past(low_line) |-> timeout_stb);

    // Strobes are one cycle wide.
    p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_stb |=> !timeout_stb);

    // A mid level leaves nothing pending in the following cycle.
    p_mid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        svc_mid |=> (wdo_n && !timeout_stb));

    // No strobe follows a low-line cycle.
    p_lowline_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        low_line |=> !timeout_stb);

endmodule

// File: tb/svc_watchdog_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module svc_watchdog_bench;

    localparam int DIV  = 4;
    localparam int FAST = 6;
    localparam int SLOW = 15;
    localparam int EXT  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] svc_code = 2'b10;
    logic       base_sel = 1'b1;
    logic       speed_sel = 1'b1;
    logic       ext_tick = 1'b0;
    logic       low_line = 1'b0;
    logic       wdo_n;
    logic       timeout_stb;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    svc_watchdog #(
        .CLK_DIV    (DIV),
        .FAST_TICKS (FAST),
        .SLOW_TICKS (SLOW),
        .EXT_TICKS  (EXT)
    ) u_svc_watchdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .svc_code    (svc_code),
        .base_sel    (base_sel),
        .speed_sel   (speed_sel),
        .ext_tick    (ext_tick),
        .low_line    (low_line),
        .wdo_n       (wdo_n),
        .timeout_stb (timeout_stb)
    );

    // Reference model state (behavioural, integer based).
    int in_hist[$];
    int tk_hist[$];
    int prev_lvl = 2;
    int prev_tick = 0;
    int phase = 0;
    int count = 0;
    int m_fault = 0;
    int m_stb = 0;
    int cyc = 0;
    int last_stb_cyc = -1;
    int last_interval = 0;
    int stb_seen = 0;

    function automatic int lvl_of(input int code);
        if (code >= 2) return 2;
        return code;
    endfunction

    // Model update: the design sees inputs two edges late.
    always @(posedge clk) begin
        int lvl, tk, lim, adv, rst_cnt, f;
        if (!rst_n) begin
            in_hist = {2, 2};
            tk_hist = {0, 0};
            prev_lvl = 2; prev_tick = 0; phase = 0; count = 0;
            m_fault = 0; m_stb = 0;
        end else begin
            lvl = lvl_of(in_hist[0]);
            tk = tk_hist[0];
            adv = base_sel ? (phase == DIV - 1) : (tk == 1 && prev_tick == 0);
            lim = !base_sel ? EXT : (speed_sel ? FAST : SLOW);
            rst_cnt = (lvl != prev_lvl) || (lvl == 2) || low_line;
            f = !rst_cnt && adv && (count >= lim - 1);
            if (rst_cnt || f) count = 0;
            else if (adv) count++;
            if (rst_cnt) m_fault = 0;
            else if (f) m_fault = 1;
            m_stb = f;
            phase = (phase == DIV - 1) ? 0 : phase + 1;
            prev_lvl = lvl;
            prev_tick = tk;
            void'(in_hist.pop_front());
            void'(tk_hist.pop_front());
            in_hist.push_back(int'(svc_code));
            tk_hist.push_back(int'(ext_tick));
        end
        cyc++;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare against the model on every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'(wdo_n), (m_fault && !low_line) ? 0 : 1, "wdo_n vs model");
            check(cur_req, int'(timeout_stb), m_stb, "timeout_stb vs model");
            if (timeout_stb) begin
                stb_seen++;
                if (last_stb_cyc >= 0) last_interval = cyc - last_stb_cyc;
                last_stb_cyc = cyc;
            end
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic start_stall();
        stb_seen = 0;
        last_stb_cyc = -1;
        last_interval = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1500000;
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state.
        wait_clks(4);
        check("R1", int'(wdo_n), 1, "wdo_n in reset");
        check("R1", int'(timeout_stb), 0, "stb in reset");
        rst_n = 1'b1;
        wait_clks(1);
        check("R1", int'(wdo_n), 1, "wdo_n after reset");
        check("R1", int'(timeout_stb), 0, "stb after reset");

        // R3: toggling faster than the fast timeout (24 clocks) never times out.
        cur_req = "R3";
        start_stall();
        for (int k = 0; k < 12; k++) begin
            svc_code = (k % 2) ? 2'b01 : 2'b00;
            wait_clks(10);
        end
        check("R3", stb_seen, 0, "strobes while toggling");
        check("R3", int'(wdo_n), 1, "wdo_n while toggling");

        // R4/R5/R8: hold low with the fast base.
        cur_req = "R4";
        svc_code = 2'b00;
        start_stall();
        wait_clks(30);
        check("R4", int'(wdo_n), 0, "wdo_n after fast stall");
        check("R4", (stb_seen >= 1) ? 1 : 0, 1, "first strobe seen");
        cur_req = "R5";
        wait_clks(60);
        check("R5", (stb_seen >= 3) ? 1 : 0, 1, "repeated strobes");
        check("R8", last_interval, FAST * DIV, "fast strobe spacing");
        check("R5", int'(wdo_n), 0, "wdo_n held during stall");

        // R6: a transition clears the fault three edges later.
        cur_req = "R6";
        svc_code = 2'b01;
        wait_clks(2);
        check("R6", int'(wdo_n), 0, "wdo_n before clear");
        wait_clks(1);
        check("R6", int'(wdo_n), 1, "wdo_n after transition");

        // R8: slow timeout while holding high.
        cur_req = "R8";
        speed_sel = 1'b0;
        start_stall();
        wait_clks(200);
        check("R8", last_interval, SLOW * DIV, "slow strobe spacing");
        check("R8", int'(wdo_n), 0, "wdo_n after slow stall");

        // R7: low_line forces wdo_n high at once and suppresses strobes.
        cur_req = "R7";
        low_line = 1'b1;
        start_stall();
        #1;
        check("R7", int'(wdo_n), 1, "wdo_n forced by low_line");
        wait_clks(150);
        check("R7", stb_seen, 0, "no strobe under low_line");
        check("R7", int'(wdo_n), 1, "wdo_n under low_line");
        low_line = 1'b0;
        wait_clks(1);
        check("R7", int'(wdo_n), 1, "fault cleared by low_line");

        // R2: both mid codes disable the timer.
        cur_req = "R2";
        speed_sel = 1'b1;
        svc_code = 2'b10;
        start_stall();
        wait_clks(120);
        check("R2", stb_seen, 0, "no strobe at mid 10");
        svc_code = 2'b11;
        wait_clks(120);
        check("R2", stb_seen, 0, "no strobe at mid 11");
        check("R2", int'(wdo_n), 1, "wdo_n at mid");

        // R9: external base, no ticks: no timeout.
        cur_req = "R9";
        base_sel = 1'b0;
        svc_code = 2'b00;
        start_stall();
        wait_clks(150);
        check("R9", stb_seen, 0, "no strobe without ext ticks");
        // R9: ext tick train, period 6 clocks.
        for (int k = 0; k < 20; k++) begin
            ext_tick = 1'b1;
            wait_clks(3);
            ext_tick = 1'b0;
            wait_clks(3);
        end
        check("R9", (stb_seen >= 2) ? 1 : 0, 1, "strobes from ext ticks");
        check("R9", last_interval, EXT * 6, "ext strobe spacing");
        check("R9", int'(wdo_n), 0, "wdo_n after ext stall");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule